// File: doc/BRIEF.md
# Multi-Angle Shift-Add Constant Rotator

This block rotates a signed fixed-point complex sample by one of a small, fixed set of angles. It contains no multiplier. Each angle is represented by a constant integer pair (C, S). The block returns the exact complex product (re + j·im)·(C + j·S) one clock after the sample is presented. The product is kept at full growth width, so it never wraps.

The coefficient pairs are parameters that are chosen offline. They are meant to share one common magnitude, so every angle carries the same output gain and the consumer can treat that gain as a single fixed scale. The block itself applies no scaling correction and no rounding.

At build time each pair is sorted into one of four shapes:
- purely real;
- purely imaginary;
- equal magnitude on both parts (odd multiples of 45 degrees);
- general.

Each shape is mapped onto four shared shift-and-add lanes. The angle-select input drives the small multiplexers that reconfigure which operand each lane reads and which signed-digit shifts it accumulates. The cheaper shapes leave lanes idle. The 45-degree shape first forms the sum and difference of the input parts and then needs only one constant per output.

Top module: `rot_shiftadd_top`

## Requirements
- R1: For an angle whose pair has both parts non-zero and unequal in magnitude, the output is out_re = re·C − im·S and out_im = re·S + im·C. With the default table this is select code 3, where (C, S) = (27, 15).
- R2: For a purely real pair (S = 0), the output is out_re = re·C and out_im = im·C. With the default table this is select code 0, where (C, S) = (31, 0).
- R3: For a purely imaginary pair (C = 0), the output is out_re = −im·S and out_im = re·S. With the default table this is select code 2, where (C, S) = (0, −31).
- R4: For a pair with |C| = |S|, the output is the same exact complex product, for both opposite signs and matching signs. With the default table these are select code 1, where (C, S) = (22, −22), and select code 4, where (C, S) = (−22, −22).
- R5: The result is exact, without wrap-around, for the extreme input values −2^(DW−1) and 2^(DW−1)−1 on either part. The output width is DW+CW+1.
- R6: A select code at or above the number of angles (codes 5, 6 and 7 by default), when presented with in_valid high, produces zero on both outputs.
- R7: out_valid equals in_valid of the previous clock cycle.
- R8: While in_valid is low, out_re and out_im keep their previous values, whatever the data and select inputs do.
- R9: While rst_n is low, out_valid, out_re and out_im are zero. They clear as soon as rst_n falls, and they stay zero even if in_valid is high.
- R10: The select code may change on every cycle. Each output reflects only the select code and data that were presented with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample qualifier and output register enable |
| in_sel | input | SELW | Angle select code |
| in_re | input | DW | Signed real part of the input |
| in_im | input | DW | Signed imaginary part of the input |
| out_valid | output | 1 | Registered copy of in_valid |
| out_re | output | DW+CW+1 | Signed real part of the rotated sample |
| out_im | output | DW+CW+1 | Signed imaginary part of the rotated sample |

## Verification
A wrong entry in the per-angle configuration shows up on the very next cycle in which that select code is used with valid data. The typical symptoms are a lane reading the wrong operand, or a signed digit with the wrong sign or position. The output then differs from the exact complex product for almost every data value, and the imaginary and real results fail independently. A missing sign bit in the sum/difference stage or in a lane's accumulator is different: it stays hidden until the inputs approach full scale. For this reason the extreme corner values are presented for every angle. A broken register enable or reset path appears within one cycle as a held value that changes, or as a non-zero output during reset.

// File: rtl/rot_pkg.sv
`timescale 1ns/1ps
package rot_pkg;

  localparam int MAX_DIG = 16;
  localparam int NLANE   = 4;

  // operand a lane reads
  typedef enum logic [1:0] {
    OP_RE  = 2'd0,
    OP_IM  = 2'd1,
    OP_SUM = 2'd2,
    OP_DIF = 2'd3
  } opnd_e;

  // signed digit encoding
  localparam logic [1:0] DG_ZERO  = 2'b00;
  localparam logic [1:0] DG_PLUS  = 2'b01;
  localparam logic [1:0] DG_MINUS = 2'b11;

  typedef logic [MAX_DIG-1:0][1:0] digvec_t;

  typedef struct packed {
    opnd_e   op;
    digvec_t dig;
  } lane_cfg_t;

  typedef enum logic [1:0] {
    SH_GENERAL = 2'd0,
    SH_REAL    = 2'd1,
    SH_IMAG    = 2'd2,
    SH_DIAG    = 2'd3
  } shape_e;

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  // canonical signed-digit recoding of a small signed integer
  function automatic digvec_t to_csd(int value);
    digvec_t d;
    int      v;
    d = '0;
    v = value;
    for (int k = 0; k < MAX_DIG; k++) begin
      if ((v & 1) != 0) begin
        if ((v & 3) == 3) begin
          d[k] = DG_MINUS;
          v    = v + 1;
        end else begin
          d[k] = DG_PLUS;
          v    = v - 1;
        end
      end
      v = v >>> 1;
    end
    return d;
  endfunction

  function automatic shape_e classify(int c, int s);
    if (s == 0)                return SH_REAL;
    if (c == 0)                return SH_IMAG;
    if (iabs(c) == iabs(s))    return SH_DIAG;
    return SH_GENERAL;
  endfunction

  // lanes 0,1 feed the real output, lanes 2,3 the imaginary output
  function automatic lane_cfg_t lane_setup(int c, int s, int lane);
    lane_cfg_t r;
    opnd_e     op;
    int        k;
    op = OP_RE;
    k  = 0;
    case (classify(c, s))
      SH_REAL: begin
        if (lane == 0) begin op = OP_RE; k = c; end
        if (lane == 3) begin op = OP_IM; k = c; end
      end
      SH_IMAG: begin
        if (lane == 1) begin op = OP_IM; k = -s; end
        if (lane == 2) begin op = OP_RE; k = s;  end
      end
      SH_DIAG: begin
        if ((c > 0) == (s > 0)) begin
          if (lane == 0) begin op = OP_DIF; k = c; end
          if (lane == 2) begin op = OP_SUM; k = c; end
        end else begin
          if (lane == 0) begin op = OP_SUM; k = c; end
          if (lane == 2) begin op = OP_DIF; k = s; end
        end
      end
      default: begin
        if (lane == 0) begin op = OP_RE; k = c;  end
        if (lane == 1) begin op = OP_IM; k = -s; end
        if (lane == 2) begin op = OP_RE; k = s;  end
        if (lane == 3) begin op = OP_IM; k = c;  end
      end
    endcase
    r.op  = op;
    r.dig = to_csd(k);
    return r;
  endfunction

endpackage

// File: rtl/rot_coef_table.sv
`timescale 1ns/1ps
module rot_coef_table
  import rot_pkg::*;
#(
  parameter int                    NANG    = 5,
  parameter int                    SELW    = 3,
  parameter int                    CW      = 6,
  parameter int                    NDIG    = CW + 1,
  parameter logic [NANG*CW-1:0]    COEF_RE = '0,
  parameter logic [NANG*CW-1:0]    COEF_IM = '0
) (
  input  logic [SELW-1:0]                  sel,
  output logic [NLANE-1:0][1:0]            op_sel,
  output logic [NLANE-1:0][NDIG-1:0][1:0]  dig
);

  logic [NLANE-1:0][1:0]           tbl_op  [NANG];
  logic [NLANE-1:0][NDIG-1:0][1:0] tbl_dig [NANG];

  for (genvar a = 0; a < NANG; a++) begin : g_ang
    for (genvar l = 0; l < NLANE; l++) begin : g_lane
      localparam lane_cfg_t CFG = lane_setup(int'($signed(COEF_RE[a*CW +: CW])),
                                             int'($signed(COEF_IM[a*CW +: CW])), l);
      assign tbl_op[a][l]  = CFG.op;
      assign tbl_dig[a][l] = CFG.dig[NDIG-1:0];
    end
  end

  // codes without an angle select an all-zero configuration
  always_comb begin
    op_sel = '0;
    dig    = '0;
    for (int a = 0; a < NANG; a++) begin
      if (int'(sel) == a) begin
        op_sel = tbl_op[a];
        dig    = tbl_dig[a];
      end
    end
  end

endmodule

// File: rtl/rot_preadd.sv
`timescale 1ns/1ps
module rot_preadd #(
  parameter int DW = 12
) (
  input  logic signed [DW-1:0] xr,
  input  logic signed [DW-1:0] xi,
  output logic signed [DW:0]   sum,
  output logic signed [DW:0]   dif
);

  always_comb begin
    sum = (DW+1)'(xr) + (DW+1)'(xi);
    dif = (DW+1)'(xr) - (DW+1)'(xi);
  end

endmodule

// File: rtl/rot_csd_lane.sv
`timescale 1ns/1ps
module rot_csd_lane
  import rot_pkg::*;
#(
  parameter int DW   = 12,
  parameter int NDIG = 7,
  parameter int IW   = 20
) (
  input  logic signed [DW-1:0]   xr,
  input  logic signed [DW-1:0]   xi,
  input  logic signed [DW:0]     sum,
  input  logic signed [DW:0]     dif,
  input  logic [1:0]             op_sel,
  input  logic [NDIG-1:0][1:0]   dig,
  output logic signed [IW-1:0]   prod
);

  logic signed [IW-1:0] opx;
  logic signed [IW-1:0] term;
  logic signed [IW-1:0] acc;

  // operand multiplexer
  always_comb begin
    case (op_sel)
      OP_RE:   opx = IW'(xr);
      OP_IM:   opx = IW'(xi);
      OP_SUM:  opx = IW'(sum);
      default: opx = IW'(dif);
    endcase
  end

  // shift-and-add chain steered by the signed digits
  always_comb begin
    acc  = '0;
    term = '0;
    for (int k = 0; k < NDIG; k++) begin
      term = opx <<< k;
      if (dig[k] == DG_PLUS) begin
        acc = acc + term;
      end else if (dig[k] == DG_MINUS) begin
        acc = acc - term;
      end
    end
    prod = acc;
  end

endmodule

// File: rtl/rot_shiftadd_top.sv
`timescale 1ns/1ps
module rot_shiftadd_top
  import rot_pkg::*;
#(
  parameter int                 DW      = 12,
  parameter int                 CW      = 6,
  parameter int                 NANG    = 5,
  parameter int                 SELW    = 3,
  parameter logic [NANG*CW-1:0] COEF_RE = {-6'sd22, 6'sd27, 6'sd0, 6'sd22, 6'sd31},
  parameter logic [NANG*CW-1:0] COEF_IM = {-6'sd22, 6'sd15, -6'sd31, -6'sd22, 6'sd0},
  localparam int                OW      = DW + CW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [SELW-1:0]      in_sel,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_re,
  output logic signed [OW-1:0] out_im
);

  localparam int NDIG = CW + 1;
  localparam int IW   = OW + 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe[1];

  // shared sum / difference of the input parts
  logic signed [DW:0] pre_sum;
  logic signed [DW:0] pre_dif;

  rot_preadd #(.DW(DW)) u_preadd (
    .xr  (in_re),
    .xi  (in_im),
    .sum (pre_sum),
    .dif (pre_dif)
  );

  // per-angle multiplexer settings
  logic [NLANE-1:0][1:0]           cfg_op;
  logic [NLANE-1:0][NDIG-1:0][1:0] cfg_dig;

  rot_coef_table #(
    .NANG    (NANG),
    .SELW    (SELW),
    .CW      (CW),
    .NDIG    (NDIG),
    .COEF_RE (COEF_RE),
    .COEF_IM (COEF_IM)
  ) u_table (
    .sel    (in_sel),
    .op_sel (cfg_op),
    .dig    (cfg_dig)
  );

  // four shared shift-and-add lanes
  logic signed [IW-1:0] lane_prod [NLANE];

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    rot_csd_lane #(
      .DW   (DW),
      .NDIG (NDIG),
      .IW   (IW)
    ) u_lane (
      .xr     (in_re),
      .xi     (in_im),
      .sum    (pre_sum),
      .dif    (pre_dif),
      .op_sel (cfg_op[l]),
      .dig    (cfg_dig[l]),
      .prod   (lane_prod[l])
    );
  end

  // next state
  logic signed [IW-1:0] re_full;
  logic signed [IW-1:0] im_full;
  logic signed [OW-1:0] re_nxt;
  logic signed [OW-1:0] im_nxt;
  logic                 load_en;

  always_comb begin
    re_full = lane_prod[0] + lane_prod[1];
    im_full = lane_prod[2] + lane_prod[3];
    load_en = in_valid;
    re_nxt  = re_full[OW-1:0];
    im_nxt  = im_full[OW-1:0];
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      out_valid <= in_valid;
      if (load_en) begin
        out_re <= re_nxt;
        out_im <= im_nxt;
      end
    end
  end

endmodule

// File: rtl/rot_shiftadd_chk.sv
`timescale 1ns/1ps
module rot_shiftadd_chk
  import rot_pkg::*;
#(
  parameter int                 DW      = 12,
  parameter int                 CW      = 6,
  parameter int                 NANG    = 5,
  parameter int                 SELW    = 3,
  parameter logic [NANG*CW-1:0] COEF_RE = '0,
  parameter logic [NANG*CW-1:0] COEF_IM = '0,
  parameter int                 OW      = DW + CW + 1
) (
  input logic                 clk,
  input logic                 rst_sync_n,
  input logic                 in_valid,
  input logic [SELW-1:0]      in_sel,
  input logic signed [DW-1:0] in_re,
  input logic signed [DW-1:0] in_im,
  input logic                 out_valid,
  input logic signed [OW-1:0] out_re,
  input logic signed [OW-1:0] out_im
);

  int                   c_sel;
  int                   s_sel;
  logic                 in_rng;
  shape_e               shp;
  logic signed [OW-1:0] exp_re;
  logic signed [OW-1:0] exp_im;

  always_comb begin
    c_sel  = 0;
    s_sel  = 0;
    in_rng = 1'b0;
    for (int a = 0; a < NANG; a++) begin
      if (int'(in_sel) == a) begin
        c_sel  = int'($signed(COEF_RE[a*CW +: CW]));
        s_sel  = int'($signed(COEF_IM[a*CW +: CW]));
        in_rng = 1'b1;
      end
    end
    shp    = classify(c_sel, s_sel);
    exp_re = OW'(longint'(in_re) * longint'(c_sel) - longint'(in_im) * longint'(s_sel));
    exp_im = OW'(longint'(in_re) * longint'(s_sel) + longint'(in_im) * longint'(c_sel));
  end

  AST_GENERAL_PRODUCT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_rng && shp == SH_GENERAL) |=> (out_re == $past(exp_re) && out_im == $past(exp_im))); // R1

  AST_REAL_PRODUCT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_rng && shp == SH_REAL) |=> (out_re == $past(exp_re) && out_im == $past(exp_im))); // R2

  AST_IMAG_PRODUCT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_rng && shp == SH_IMAG) |=> (out_re == $past(exp_re) && out_im == $past(exp_im))); // R3

  AST_DIAG_PRODUCT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_rng && shp == SH_DIAG) |=> (out_re == $past(exp_re) && out_im == $past(exp_im))); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_re != {1'b1, {(OW-1){1'b0}}}) && (out_im != {1'b1, {(OW-1){1'b0}}})); // R5

  AST_SEL_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !in_rng) |=> (out_re == '0 && out_im == '0)); // R6

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid); // R7

  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid); // R7

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> ($stable(out_re) && $stable(out_im))); // R8

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_sync_n |-> (!out_valid && out_re == '0 && out_im == '0)); // R9

endmodule

bind rot_shiftadd_top rot_shiftadd_chk #(
  .DW      (DW),
  .CW      (CW),
  .NANG    (NANG),
  .SELW    (SELW),
  .COEF_RE (COEF_RE),
  .COEF_IM (COEF_IM)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .in_valid   (in_valid),
  .in_sel     (in_sel),
  .in_re      (in_re),
  .in_im      (in_im),
  .out_valid  (out_valid),
  .out_re     (out_re),
  .out_im     (out_im)
);

// File: tb/tb_rot_shiftadd_top.sv
`timescale 1ns/1ps
module tb_rot_shiftadd_top;

  localparam int DW = 12;
  localparam int CW = 6;
  localparam int OW = DW + CW + 1;
  localparam int SELW = 3;
  localparam int NANG = 5;

  // coefficient table as given in the requirements
  localparam int BC [NANG] = '{31, 22, 0, 27, -22};
  localparam int BS [NANG] = '{0, -22, -31, 15, -22};

  logic                 clk;
  logic                 rst_n;
  logic                 in_valid;
  logic [SELW-1:0]      in_sel;
  logic signed [DW-1:0] in_re;
  logic signed [DW-1:0] in_im;
  logic                 out_valid;
  logic signed [OW-1:0] out_re;
  logic signed [OW-1:0] out_im;

  int checks;
  int errors;
  int held_re;
  int held_im;
  bit done;

  rot_shiftadd_top dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sel    (in_sel),
    .in_re     (in_re),
    .in_im     (in_im),
    .out_valid (out_valid),
    .out_re    (out_re),
    .out_im    (out_im)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int ref_re(int s, int a, int b);
    if (s >= NANG) return 0;
    return a * BC[s] - b * BS[s];
  endfunction

  function automatic int ref_im(int s, int a, int b);
    if (s >= NANG) return 0;
    return a * BS[s] + b * BC[s];
  endfunction

  function automatic string tag_of(int s);
    case (s)
      0:       return "R2";
      1:       return "R4";
      2:       return "R3";
      3:       return "R1";
      4:       return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic check_out(input string req, input logic ev, input int er, input int ei);
    checks++;
    if (out_valid !== ev || $signed(out_re) != er || $signed(out_im) != ei) begin
      errors++;
      $display("FAIL %s actual valid=%0b re=%0d im=%0d expected valid=%0b re=%0d im=%0d",
               req, out_valid, $signed(out_re), $signed(out_im), ev, er, ei);
    end
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic cycle(input logic v, input int s, input int a, input int b, input string req);
    in_valid = v;
    in_sel   = SELW'(s);
    in_re    = DW'(a);
    in_im    = DW'(b);
    @(negedge clk);
    if (v) begin
      held_re = ref_re(s, a, b);
      held_im = ref_im(s, a, b);
    end
    check_out(req, v, held_re, held_im);
  endtask

  initial begin
    checks   = 0;
    errors   = 0;
    held_re  = 0;
    held_im  = 0;
    done     = 1'b0;
    in_valid = 1'b0;
    in_sel   = '0;
    in_re    = '0;
    in_im    = '0;
    rst_n    = 1'b1;
    #1 rst_n = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check_out("R9", 1'b0, 0, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_out("R9", 1'b0, 0, 0);

    // every angle, plain values and extreme corners
    for (int s = 0; s < NANG; s++) begin
      cycle(1'b1, s, 1, 0, tag_of(s));
      cycle(1'b1, s, 0, 1, tag_of(s));
      cycle(1'b1, s, 100, -37, tag_of(s));
      cycle(1'b1, s, -2048, -2048, "R5");
      cycle(1'b1, s, 2047, 2047, "R5");
      cycle(1'b1, s, -2048, 2047, "R5");
      cycle(1'b1, s, 2047, -2048, "R5");
    end

    // unused select codes
    for (int s = NANG; s < 8; s++) begin
      cycle(1'b1, 3, 500, 500, "R1");
      cycle(1'b1, s, 1234, -777, "R6");
      cycle(1'b1, s, -2048, -2048, "R6");
    end

    // idle cycles hold the last result
    cycle(1'b1, 3, -1000, 333, "R1");
    cycle(1'b0, 1, 2047, -2048, "R8");
    cycle(1'b0, 6, -5, 9, "R8");
    cycle(1'b0, 0, 0, 0, "R7");

    // select toggling every cycle
    for (int n = 0; n < 40; n++) begin
      cycle(1'b1, n % 5, n * 37 - 700, 600 - n * 29, "R10");
    end

    // constrained random with extremes mixed in
    for (int n = 0; n < 1500; n++) begin
      int  a;
      int  b;
      int  s;
      logic v;
      v = (($urandom % 5) != 0);
      s = int'($urandom % 8);
      a = int'($signed(DW'($urandom)));
      b = int'($signed(DW'($urandom)));
      if ((n % 7) == 0) a = ((n % 2) == 0) ? -2048 : 2047;
      if ((n % 11) == 0) b = ((n % 3) == 0) ? -2048 : 2047;
      cycle(v, s, a, b, v ? tag_of(s) : "R8");
    end

    // reset in the middle of traffic
    cycle(1'b1, 3, 1500, -1500, "R1");
    rst_n    = 1'b0;
    in_valid = 1'b1;
    in_sel   = 3'd3;
    in_re    = 12'sd700;
    in_im    = 12'sd700;
    #1;
    check_out("R9", 1'b0, 0, 0);
    @(negedge clk);
    check_out("R9", 1'b0, 0, 0);
    rst_n    = 1'b1;
    in_valid = 1'b0;
    held_re  = 0;
    held_im  = 0;
    repeat (3) @(negedge clk);
    check_out("R9", 1'b0, 0, 0);
    cycle(1'b1, 4, -2048, 2047, "R4");
    cycle(1'b1, 2, 2047, -2048, "R3");
    cycle(1'b0, 2, 0, 0, "R8");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule